// File: doc/BRIEF.md
# GPIB Address Status Tracker

This block follows the command bytes a GPIB controller places on the bus while the attention line is asserted. From those bytes it keeps the addressed state of one device: whether the device is talker or listener, whether its primary address has been seen while it waits for a secondary address, and whether a serial poll is in progress. These flags, the controller-in-charge indication and the live attention level form one 8-bit read-only status word. A host reads that word by pulsing a read strobe.

Each role (listener, talker) runs its own copy of one four-state machine. The states are `RS_IDLE` (not addressed, no primary seen), `RS_PRI` (primary seen, waiting for secondary), `RS_ADDR` (addressed) and `RS_ADDR_PRI` (addressed, primary seen again). Single-level mode moves only between `RS_IDLE` and `RS_ADDR`. Its transitions are: own primary (to `RS_ADDR`), unaddress, the peer role's own primary, and, for the talker, another device's talk address (all three to `RS_IDLE`). Two-level mode has more transitions. Own primary sets the primary flag (`RS_IDLE`→`RS_PRI`, `RS_ADDR`→`RS_ADDR_PRI`). Any other primary command clears that flag. A matching secondary while the flag is set moves the machine to an addressed state. A matching secondary taken by the peer role drops the addressed bit. A serial-poll machine has two states. It goes `SP_OFF`→`SP_ON` on poll-enable while talker, and `SP_ON`→`SP_OFF` on poll-disable or reset. Power-on reset and the chip-reset pulse act as one synchronous clear.

Top module: `gpib_addr_status`

## Requirements
- R1: When `pon_rst` or `chip_rst_cmd` is high at a clock edge, TA, LA, TPAS, LPAS, SPMS and `rd_data` are all 0 after that edge.
- R2: A high `rd_stb` at an edge loads the status word into `rd_data`. With `rd_stb` low, `rd_data` holds its value. The word's bits are: bit7 CIC, bit6 ATN level, bit5 SPMS, bit4 LPAS, bit3 TPAS, bit2 LA, bit1 TA, bit0 constant 0.
- R3: Bit7 is `ctrl_active | ctrl_standby`, and bit6 is the level of `atn_n`, both as present at the strobe edge.
- R4: A command is taken only when `cmd_valid` is 1 and `atn_n` is 0, and `dio[7]` is ignored. Bits [6:5] of the command select the group: 00 universal, 01 listen, 10 talk, 11 secondary. Bits [4:0] carry the address.
- R5: In single-level mode (`addr_mode`=01), listen address 0x20+`my_pri_addr` sets LA and clears TA. Talk address 0x40+`my_pri_addr` sets TA and clears LA.
- R6: 0x3F (unlisten) clears LA and 0x5F (untalk) clears TA in any mode. A talk address of another device clears TA. A listen address of another device leaves LA unchanged.
- R7: In two-level mode (`addr_mode`=10), own listen or talk primary sets LPAS or TPAS, without setting LA or TA. Any other byte in 0x20–0x5F clears the flag it did not set. In single-level mode LPAS and TPAS stay 0.
- R8: In two-level mode, secondary 0x60+`my_sec_addr` sets LA and clears TA while LPAS is 1, and sets TA and clears LA while TPAS is 1. A secondary that arrives with both flags 0, or that does not match, changes nothing.
- R9: 0x18 (poll enable) sets SPMS when TA is 1 and is ignored when TA is 0.
- R10: 0x19 (poll disable) clears SPMS. Losing TA leaves SPMS set.
- R11: With `addr_mode` 00 or 11, TA, LA, TPAS and LPAS are 0 one cycle later and stay 0.
- R12: Device address 31 never matches an own primary, so 0x3F and 0x5F never address the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pon_rst | input | 1 | Power-on reset, synchronous, active high |
| chip_rst_cmd | input | 1 | Chip-reset command pulse, synchronous |
| atn_n | input | 1 | Bus attention line, active low |
| cmd_valid | input | 1 | Byte on `dio` is valid this cycle |
| dio | input | 8 | Bus data byte |
| my_pri_addr | input | 5 | Programmed primary address |
| my_sec_addr | input | 5 | Programmed secondary address |
| addr_mode | input | 2 | 00 off, 01 single-level, 10 two-level, 11 off |
| ctrl_active | input | 1 | Controller function active |
| ctrl_standby | input | 1 | Controller function standby |
| rd_stb | input | 1 | Read strobe for the status word |
| rd_data | output | 8 | Captured status word |

## Verification
A command byte presented at one clock edge changes the address and poll flags right after that edge. These flags reach `rd_data` only at the next edge at which `rd_stb` is high, so every result is visible two edges after the command. The bench drives each byte for one cycle from the falling edge and drops it at the next falling edge. It then raises `rd_stb` for one cycle and compares `rd_data` at the falling edge after that. CIC and ATN are sampled at the strobe edge itself, and the bench holds those inputs steady across it. For the hold check, the bench changes state without a strobe and then compares the old word.

// File: rtl/gpib_as_pkg.sv
package gpib_as_pkg;

    localparam int unsigned GP_ADDR_W = 5;

    typedef enum logic [1:0] {
        AM_OFF    = 2'b00,
        AM_SINGLE = 2'b01,
        AM_TWO    = 2'b10,
        AM_RSVD   = 2'b11
    } addr_mode_e;

    // state code is {addressed, primary_seen}
    typedef enum logic [1:0] {
        RS_IDLE     = 2'b00,
        RS_PRI      = 2'b01,
        RS_ADDR     = 2'b10,
        RS_ADDR_PRI = 2'b11
    } role_state_e;

    typedef enum logic {
        SP_OFF = 1'b0,
        SP_ON  = 1'b1
    } spoll_state_e;

    localparam logic [1:0] GRP_UNIV   = 2'b00;
    localparam logic [1:0] GRP_LISTEN = 2'b01;
    localparam logic [1:0] GRP_TALK   = 2'b10;
    localparam logic [1:0] GRP_SEC    = 2'b11;

    typedef struct packed {
        logic spe;
        logic spd;
        logic mla;
        logic unl;
        logic mta;
        logic unt;
        logic ota;
        logic pcg;
        logic msa;
    } cmd_ev_t;

endpackage

// File: rtl/gpib_cmd_decode.sv
module gpib_cmd_decode
    import gpib_as_pkg::*;
#(
    parameter int unsigned ADDR_W = GP_ADDR_W
) (
    input  logic [ADDR_W+1:0] cmd_i,
    input  logic              strobe_i,
    input  logic              atn_n_i,
    input  logic [ADDR_W-1:0] pri_i,
    input  logic [ADDR_W-1:0] sec_i,
    output cmd_ev_t           ev_o
);

    localparam logic [ADDR_W-1:0] ALL1   = '1;
    localparam logic [ADDR_W-1:0] SPE_LO = ADDR_W'(24);
    localparam logic [ADDR_W-1:0] SPD_LO = ADDR_W'(25);

    logic              hit;
    logic [1:0]        grp;
    logic [ADDR_W-1:0] lo;
    logic              pri_ok;

    assign hit    = strobe_i & ~atn_n_i;
    assign grp    = cmd_i[ADDR_W+1:ADDR_W];
    assign lo     = cmd_i[ADDR_W-1:0];
    assign pri_ok = (pri_i != ALL1);

    always_comb begin
        ev_o = '0;
        if (hit) begin
            case (grp)
                GRP_UNIV: begin
                    ev_o.spe = (lo == SPE_LO);
                    ev_o.spd = (lo == SPD_LO);
                end
                GRP_LISTEN: begin
                    ev_o.pcg = 1'b1;
                    ev_o.unl = (lo == ALL1);
                    ev_o.mla = pri_ok && (lo == pri_i);
                end
                GRP_TALK: begin
                    ev_o.pcg = 1'b1;
                    ev_o.unt = (lo == ALL1);
                    ev_o.mta = pri_ok && (lo == pri_i);
                    ev_o.ota = (lo != ALL1) && (lo != pri_i);
                end
                default: begin
                    ev_o.msa = (lo == sec_i);
                end
            endcase
        end
    end

endmodule

// File: rtl/gpib_role_fsm.sv
module gpib_role_fsm
    import gpib_as_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  addr_mode_e mode_i,
    input  logic       mine_i,
    input  logic       peer_mine_i,
    input  logic       unaddr_i,
    input  logic       other_i,
    input  logic       pcg_i,
    input  logic       msa_i,
    input  logic       peer_pas_i,
    output logic       addr_o,
    output logic       pas_o
);

    role_state_e state_q, state_d;
    logic cur_a, cur_p, nx_a, nx_p;

    assign cur_a = state_q[1];
    assign cur_p = state_q[0];

    always_comb begin
        nx_a = 1'b0;
        nx_p = 1'b0;
        unique case (mode_i)
            AM_SINGLE: begin
                nx_a = (cur_a & ~(unaddr_i | peer_mine_i | other_i)) | mine_i;
                nx_p = 1'b0;
            end
            AM_TWO: begin
                nx_p = pcg_i ? mine_i : cur_p;
                nx_a = cur_a;
                if (unaddr_i || other_i)
                    nx_a = 1'b0;
                if (msa_i && cur_p)
                    nx_a = 1'b1;
                else if (msa_i && peer_pas_i)
                    nx_a = 1'b0;
            end
            AM_OFF, AM_RSVD: begin
                nx_a = 1'b0;
                nx_p = 1'b0;
            end
        endcase
        state_d = role_state_e'({nx_a, nx_p});
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            state_q <= RS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE:     begin addr_o = 1'b0; pas_o = 1'b0; end
            RS_PRI:      begin addr_o = 1'b0; pas_o = 1'b1; end
            RS_ADDR:     begin addr_o = 1'b1; pas_o = 1'b0; end
            RS_ADDR_PRI: begin addr_o = 1'b1; pas_o = 1'b1; end
        endcase
    end

    // R1
    role_rst_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (!addr_o && !pas_o));

    // R11
    role_off_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == AM_OFF || mode_i == AM_RSVD) |=> (!addr_o && !pas_o));

    // R7
    role_single_no_pas_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == AM_SINGLE) |=> !pas_o);

    // R8
    role_two_addr_via_sec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == AM_TWO && !addr_o && !(msa_i && pas_o)) |=> !addr_o);

endmodule

// File: rtl/gpib_spoll_fsm.sv
module gpib_spoll_fsm
    import gpib_as_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic spe_i,
    input  logic spd_i,
    input  logic talker_i,
    output logic spms_o
);

    spoll_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SP_OFF: if (spe_i && talker_i) state_d = SP_ON;
            SP_ON:  if (spd_i)             state_d = SP_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            state_q <= SP_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SP_OFF: spms_o = 1'b0;
            SP_ON:  spms_o = 1'b1;
        endcase
    end

    // R9
    spoll_enter_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (spe_i && talker_i) |=> spms_o);

    // R10
    spoll_leave_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        spd_i |=> !spms_o);

    // R1
    spoll_rst_chk: assert property (@(posedge clk_i)
        rst_i |=> !spms_o);

endmodule

// File: rtl/gpib_addr_status.sv
module gpib_addr_status
    import gpib_as_pkg::*;
#(
    parameter int unsigned ADDR_W = GP_ADDR_W
) (
    input  logic              clk,
    input  logic              pon_rst,
    input  logic              chip_rst_cmd,
    input  logic              atn_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W+2:0] dio,
    input  logic [ADDR_W-1:0] my_pri_addr,
    input  logic [ADDR_W-1:0] my_sec_addr,
    input  logic [1:0]        addr_mode,
    input  logic              ctrl_active,
    input  logic              ctrl_standby,
    input  logic              rd_stb,
    output logic [ADDR_W+2:0] rd_data
);

    localparam int unsigned CMD_W  = ADDR_W + 2;
    localparam int unsigned N_ROLE = 2;  // 0 listener, 1 talker
    localparam logic [CMD_W-1:0] UNL_CODE = {GRP_LISTEN, {ADDR_W{1'b1}}};

    logic              rst;
    addr_mode_e        mode;
    cmd_ev_t           ev;
    logic [N_ROLE-1:0] mine_v, unad_v, other_v, addr_v, pas_v;
    logic              spms;
    logic [ADDR_W+2:0] status;
    logic [ADDR_W+2:0] rd_q;

    assign rst  = pon_rst | chip_rst_cmd;
    assign mode = addr_mode_e'(addr_mode);

    gpib_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cmd_i    (dio[CMD_W-1:0]),
        .strobe_i (cmd_valid),
        .atn_n_i  (atn_n),
        .pri_i    (my_pri_addr),
        .sec_i    (my_sec_addr),
        .ev_o     (ev)
    );

    assign mine_v  = {ev.mta, ev.mla};
    assign unad_v  = {ev.unt, ev.unl};
    assign other_v = {ev.ota, 1'b0};

    for (genvar r = 0; r < N_ROLE; r++) begin : g_role
        gpib_role_fsm u_role (
            .clk_i       (clk),
            .rst_i       (rst),
            .mode_i      (mode),
            .mine_i      (mine_v[r]),
            .peer_mine_i (mine_v[N_ROLE-1-r]),
            .unaddr_i    (unad_v[r]),
            .other_i     (other_v[r]),
            .pcg_i       (ev.pcg),
            .msa_i       (ev.msa),
            .peer_pas_i  (pas_v[N_ROLE-1-r]),
            .addr_o      (addr_v[r]),
            .pas_o       (pas_v[r])
        );
    end

    gpib_spoll_fsm u_spoll (
        .clk_i    (clk),
        .rst_i    (rst),
        .spe_i    (ev.spe),
        .spd_i    (ev.spd),
        .talker_i (addr_v[1]),
        .spms_o   (spms)
    );

    assign status = {ctrl_active | ctrl_standby, atn_n, spms,
                     pas_v[0], pas_v[1], addr_v[0], addr_v[1], 1'b0};

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (rd_stb)
            rd_q <= status;
    end

    assign rd_data = rd_q;

    // R5
    never_both_roles_chk: assert property (@(posedge clk) disable iff (rst)
        !(addr_v[0] && addr_v[1]));

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

    // R4
    high_bit_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !atn_n && dio[CMD_W] && dio[CMD_W-1:0] == UNL_CODE) |=> !addr_v[0]);

endmodule

// File: tb/gpib_addr_status_test.sv
module gpib_addr_status_test;

    logic       clk = 1'b0;
    logic       pon_rst = 1'b1;
    logic       chip_rst_cmd = 1'b0;
    logic       atn_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] dio = 8'h00;
    logic [4:0] my_pri_addr = 5'd5;
    logic [4:0] my_sec_addr = 5'd9;
    logic [1:0] addr_mode = 2'b01;
    logic       ctrl_active = 1'b0;
    logic       ctrl_standby = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpib_addr_status uut (
        .clk(clk), .pon_rst(pon_rst), .chip_rst_cmd(chip_rst_cmd),
        .atn_n(atn_n), .cmd_valid(cmd_valid), .dio(dio),
        .my_pri_addr(my_pri_addr), .my_sec_addr(my_sec_addr),
        .addr_mode(addr_mode), .ctrl_active(ctrl_active),
        .ctrl_standby(ctrl_standby), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        pon_rst = 1'b1; cmd_valid = 1'b0; rd_stb = 1'b0; atn_n = 1'b0;
        repeat (2) @(negedge clk);
        pon_rst = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        dio = b; cmd_valid = 1'b1; atn_n = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; dio = 8'h00;
    endtask

    task automatic read_chk(input string req, input logic [7:0] exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rd_data after reset", rd_data, 8'h00);
        atn_n = 1'b1;
        read_chk("R3 atn level idle", 8'h40);
        atn_n = 1'b0;
    endtask

    task automatic t_single();
        do_reset(); addr_mode = 2'b01;
        send(8'h25); read_chk("R5 own listen", 8'h04);
        send(8'h45); read_chk("R5 own talk clears LA", 8'h02);
        send(8'h25); read_chk("R5 own listen clears TA", 8'h04);
        send(8'h27); read_chk("R6 other listen keeps LA", 8'h04);
        send(8'h3F); read_chk("R6 unlisten", 8'h00);
        send(8'h45); send(8'h47); read_chk("R6 other talker", 8'h00);
        send(8'h45); send(8'h5F); read_chk("R6 untalk", 8'h00);
    endtask

    task automatic t_gating();
        do_reset(); addr_mode = 2'b01;
        dio = 8'h25; cmd_valid = 1'b1; atn_n = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        read_chk("R4 atn high ignored", 8'h40);
        atn_n = 1'b0; dio = 8'h25; cmd_valid = 1'b0;
        @(negedge clk);
        read_chk("R4 no valid ignored", 8'h00);
        send(8'hA5); read_chk("R4 bit7 ignored", 8'h04);
        send(8'hBF); read_chk("R4 bit7 unlisten", 8'h00);
    endtask

    task automatic t_hold();
        do_reset(); addr_mode = 2'b01;
        send(8'h25); read_chk("R2 read", 8'h04);
        send(8'h3F);
        chk("R2 hold without strobe", rd_data, 8'h04);
        read_chk("R2 fresh read", 8'h00);
    endtask

    task automatic t_two();
        do_reset(); addr_mode = 2'b10;
        send(8'h25); read_chk("R7 listen primary only", 8'h10);
        send(8'h6A); read_chk("R8 other secondary", 8'h10);
        send(8'h69); read_chk("R8 listen secondary", 8'h14);
        send(8'h27); read_chk("R7 other primary clears LPAS", 8'h04);
        send(8'h45); read_chk("R7 talk primary", 8'h0C);
        send(8'h69); read_chk("R8 talk secondary", 8'h0A);
        send(8'h5F); read_chk("R6 untalk two-level", 8'h00);
        send(8'h69); read_chk("R8 secondary no flag", 8'h00);
    endtask

    task automatic t_spoll();
        do_reset(); addr_mode = 2'b01;
        send(8'h18); read_chk("R9 enable not talker", 8'h00);
        send(8'h45); send(8'h18); read_chk("R9 enable talker", 8'h22);
        send(8'h5F); read_chk("R10 untalk keeps SPMS", 8'h20);
        send(8'h19); read_chk("R10 disable", 8'h00);
    endtask

    task automatic t_cic();
        do_reset();
        ctrl_active = 1'b1; read_chk("R3 active", 8'h80);
        ctrl_active = 1'b0; ctrl_standby = 1'b1; read_chk("R3 standby", 8'h80);
        ctrl_standby = 1'b0; read_chk("R3 idle", 8'h00);
    endtask

    task automatic t_chip_rst();
        do_reset(); addr_mode = 2'b01;
        send(8'h45); send(8'h18); read_chk("R9 setup", 8'h22);
        chip_rst_cmd = 1'b1; @(negedge clk); chip_rst_cmd = 1'b0;
        chk("R1 chip reset rd_data", rd_data, 8'h00);
        read_chk("R1 chip reset state", 8'h00);
        addr_mode = 2'b10;
        send(8'h25);
        chip_rst_cmd = 1'b1; @(negedge clk); chip_rst_cmd = 1'b0;
        read_chk("R1 chip reset LPAS", 8'h00);
    endtask

    task automatic t_off();
        do_reset(); addr_mode = 2'b00;
        send(8'h25); read_chk("R11 mode 00", 8'h00);
        addr_mode = 2'b11;
        send(8'h45); read_chk("R11 mode 11", 8'h00);
        addr_mode = 2'b01; send(8'h25);
        addr_mode = 2'b00; @(negedge clk);
        read_chk("R11 switch off clears", 8'h00);
        addr_mode = 2'b01;
    endtask

    task automatic t_addr31();
        do_reset(); addr_mode = 2'b01; my_pri_addr = 5'd31;
        send(8'h3F); read_chk("R12 address 31 listen", 8'h00);
        send(8'h5F); read_chk("R12 address 31 talk", 8'h00);
        my_pri_addr = 5'd5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_gating();
        t_hold();
        t_two();
        t_spoll();
        t_cic();
        t_chip_rst();
        t_off();
        t_addr31();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule